// File: doc/BRIEF.md
# UART Holding FIFOs with Hysteresis RTS Control

This block holds received and to-be-sent bytes for one UART channel. A receive queue and a transmit queue sit between the serial engine and the host side. A single write-only control byte sets the operating mode, requests flushes and picks the receive trigger level. In byte mode each queue holds one byte. In FIFO mode each queue holds `DEPTH` bytes, 16 by default.

The selected receive trigger level, called the high mark, has two jobs. It raises the receive data interrupt, and it is the point at which the ready-to-send output is withdrawn. The output comes back only when the receive queue has drained to a fixed low mark of one byte, so the far end is not stopped and restarted on every byte. In byte mode both marks are one. The serial engine pushes received bytes and pops bytes to transmit. The host side pops received bytes and pushes bytes for transmission.

Top module: `serial_fifo_ctl`

## Requirements
- R1: After reset both levels are 0, `rts` is 1, `rx_irq` is 0, `rx_overrun` is 0, the block is in byte mode and the high-mark select is 00.
- R2: Control bit 0 selects the capacity of both queues. With 0 (byte mode) each queue accepts one byte; with 1 (FIFO mode) each accepts `DEPTH` bytes.
- R3: Each queue returns bytes in arrival order, and its read data port always shows the oldest stored byte.
- R4: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue at that clock edge. In byte mode bit 1 has no effect, and a 0 in bit 1 never changes the receive queue.
- R5: A control write with bit 0 = 1 and bit 2 = 1 empties only the transmit queue. In byte mode bit 2 has no effect, and a 0 in bit 2 never changes the transmit queue.
- R6: A control write that changes bit 0 empties the receive queue and leaves the transmit queue untouched.
- R7: Control bits 7:6 select the high mark in FIFO mode: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_irq` is 1 in the cycle after the receive level is at or above the high mark, and 0 otherwise.
- R8: `rts` goes to 0 in the cycle after the receive level reaches the high mark. It goes back to 1 in the cycle after the level is 1 or less, and it keeps its value while the level lies strictly between the low mark and the high mark.
- R9: In byte mode the high mark is 1 whatever bits 7:6 hold.
- R10: Control bits 5:3 have no effect.
- R11: A push into a full receive queue is dropped and sets `rx_overrun`. The flag stays set until reset or until the receive queue is emptied by a control write.
- R12: When a flush and a push to the same queue fall in the same cycle, the flush wins and the queue is left empty.
- R13: A pop from an empty queue is ignored. A push and a pop in the same cycle on a queue that is neither empty nor full leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| rx_push | input | 1 | Serial engine stores a received byte |
| rx_wdata | input | DATA_W | Received byte |
| rx_pop | input | 1 | Host removes the oldest received byte |
| rx_rdata | output | DATA_W | Oldest received byte |
| rx_level | output | CNT_W | Bytes held in the receive queue |
| tx_push | input | 1 | Host stores a byte to send |
| tx_wdata | input | DATA_W | Byte to send |
| tx_pop | input | 1 | Serial engine removes the oldest byte to send |
| tx_rdata | output | DATA_W | Oldest byte to send |
| tx_level | output | CNT_W | Bytes held in the transmit queue |
| rx_irq | output | 1 | Receive data at or above the high mark |
| rts | output | 1 | Ready to send: 1 lets the far end transmit |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |

## Verification
A control write that empties a queue can land in the same clock cycle as a push into that queue. Writing 0x03 in FIFO mode while the serial engine pushes is one such case. Writing 0x05 while the host pushes a byte to send is another. The bench drives both strobes in the same cycle and, one cycle later, expects that queue's level to be 0. A dropped push that overlaps an earlier overrun is judged the same way: the flag clears and the level reads 0.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef struct packed {
    logic [1:0] hi_sel;
    logic [2:0] unused;
    logic       tx_clr;
    logic       rx_clr;
    logic       fifo_en;
  } ctl_byte_t;

  localparam int unsigned LOW_MARK = 1;

  function automatic int unsigned high_mark(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic       fifo_mode,
  output logic [1:0] hi_sel,
  output logic       rx_flush,
  output logic       tx_flush
);
  import sfc_pkg::*;

  ctl_byte_t wr;
  assign wr = ctl_byte_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_mode <= 1'b0;
      hi_sel    <= 2'b00;
    end else if (we) begin
      fifo_mode <= wr.fifo_en;
      hi_sel    <= wr.hi_sel;
    end
  end

  // flush requests act on the write edge itself
  assign rx_flush = we && ((wr.fifo_en && wr.rx_clr) || (wr.fifo_en != fifo_mode));
  assign tx_flush = we && wr.fifo_en && wr.tx_clr;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(fifo_mode)); // R2

  AST_MODE_SWAP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[0] != fifo_mode) |=> fifo_mode == $past(wdata[0])); // R6

endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [CNT_W-1:0]  cap,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  level,
  output logic              drop
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              accept, take;

  assign accept = push && !flush && (level < cap);
  assign take   = pop && !flush && (level != '0);
  assign drop   = push && !flush && (level >= cap);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (take)   rd_ptr <= bump(rd_ptr);
      case ({accept, take})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH)); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> level == '0); // R12

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && level >= cap) |=> level == $past(level)); // R11

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !flush && level == '0) |=> level == '0); // R13

endmodule

// File: rtl/serial_fifo_ctl.sv
module serial_fifo_ctl #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [CNT_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic [CNT_W-1:0]  tx_level,
  output logic              rx_irq,
  output logic              rts,
  output logic              rx_overrun
);
  import sfc_pkg::*;

  logic             fifo_mode, rx_flush, tx_flush, rx_drop, tx_drop;
  logic [1:0]       hi_sel;
  logic [CNT_W-1:0] cap, l1, l2;

  sfc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .fifo_mode (fifo_mode),
    .hi_sel    (hi_sel),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush)
  );

  assign cap = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign l1  = CNT_W'(LOW_MARK);
  assign l2  = fifo_mode ? CNT_W'(high_mark(hi_sel)) : CNT_W'(1);

  sfc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush),
    .cap   (cap),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .level (rx_level),
    .drop  (rx_drop)
  );

  sfc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush),
    .cap   (cap),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .level (tx_level),
    .drop  (tx_drop)
  );

  // flags follow the receive level one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq     <= 1'b0;
      rts        <= 1'b1;
      rx_overrun <= 1'b0;
    end else begin
      rx_irq <= (rx_level >= l2);
      if (rx_level >= l2)      rts <= 1'b0;
      else if (rx_level <= l1) rts <= 1'b1;
      if (rx_flush)     rx_overrun <= 1'b0;
      else if (rx_drop) rx_overrun <= 1'b1;
    end
  end

  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_level > l1 && rx_level < l2) |=> rts == $past(rts)); // R8

  AST_RTS_STOP: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= l2) |=> !rts); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !rx_flush) |=> rx_overrun); // R11

  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |-> rx_level <= CNT_W'(1)); // R2

endmodule

// File: tb/serial_fifo_ctl_test.sv
`timescale 1ns/1ps
module serial_fifo_ctl_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_wdata = '0, tx_wdata = '0;
  logic [7:0] rx_rdata, tx_rdata;
  logic [CNT_W-1:0] rx_level, tx_level;
  logic rx_irq, rts, rx_overrun;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_fifo_ctl #(.DEPTH(DEPTH), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_level(rx_level),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_level(tx_level),
    .rx_irq(rx_irq), .rts(rts), .rx_overrun(rx_overrun)
  );

  // op: 0 rx push, 1 rx pop, 2 control write | arg | level | irq | rts
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {2'd2, 8'h41, 5'd0, 1'b0, 1'b1},
    {2'd0, 8'hA0, 5'd1, 1'b0, 1'b1},
    {2'd0, 8'hA1, 5'd2, 1'b0, 1'b1},
    {2'd0, 8'hA2, 5'd3, 1'b0, 1'b1},
    {2'd0, 8'hA3, 5'd4, 1'b1, 1'b0},
    {2'd0, 8'hA4, 5'd5, 1'b1, 1'b0},
    {2'd1, 8'h00, 5'd4, 1'b1, 1'b0},
    {2'd1, 8'h00, 5'd3, 1'b0, 1'b0},
    {2'd1, 8'h00, 5'd2, 1'b0, 1'b0},
    {2'd1, 8'h00, 5'd1, 1'b0, 1'b1},
    {2'd0, 8'hA5, 5'd2, 1'b0, 1'b1},
    {2'd2, 8'h81, 5'd2, 1'b0, 1'b1},
    {2'd2, 8'hC1, 5'd2, 1'b0, 1'b1},
    {2'd2, 8'h01, 5'd2, 1'b1, 1'b0},
    {2'd2, 8'h39, 5'd2, 1'b1, 1'b0},
    {2'd2, 8'h38, 5'd0, 1'b0, 1'b1},
    {2'd0, 8'hB0, 5'd1, 1'b1, 1'b0},
    {2'd0, 8'hB1, 5'd1, 1'b1, 1'b0},
    {2'd2, 8'hC0, 5'd1, 1'b1, 1'b0},
    {2'd1, 8'h00, 5'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cfg_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic settle();
    cycle();
    cycle();
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; settle();
  endtask

  task automatic rxp(input logic [7:0] v);
    rx_push = 1'b1; rx_wdata = v; cycle();
  endtask

  task automatic txp(input logic [7:0] v);
    tx_push = 1'b1; tx_wdata = v; cycle();
  endtask

  task automatic do_reset();
    rst = 1'b1; cycle(); cycle(); rst = 1'b0; cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rts", int'(rts), 1);
    chk("R1 irq", int'(rx_irq), 0);
    chk("R1 overrun", int'(rx_overrun), 0);

    // table: R7 R8 R9 R10 R6 R2 hysteresis and trigger walk
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      case (v[16:15])
        2'd0: begin rx_push = 1'b1; rx_wdata = v[14:7]; end
        2'd1: rx_pop = 1'b1;
        default: begin cfg_we = 1'b1; cfg_wdata = v[14:7]; end
      endcase
      settle();
      chk($sformatf("R8 R7 vec%0d level", i), int'(rx_level), int'(v[6:2]));
      chk($sformatf("R7 R9 vec%0d irq", i), int'(rx_irq), int'(v[1]));
      chk($sformatf("R8 R10 vec%0d rts", i), int'(rts), int'(v[0]));
    end
    chk("R11 byte-mode drop overrun", int'(rx_overrun), 1);

    // R2 R3 R11 full queue, order, overrun
    do_reset();
    cfg(8'h01);
    for (int k = 0; k < DEPTH; k++) rxp(8'h10 + 8'(k));
    settle();
    chk("R2 full level", int'(rx_level), DEPTH);
    chk("R11 no overrun yet", int'(rx_overrun), 0);
    rxp(8'hEE); settle();
    chk("R11 level after drop", int'(rx_level), DEPTH);
    chk("R11 overrun set", int'(rx_overrun), 1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3 order", int'(rx_rdata), 16'h10 + k);
      rx_pop = 1'b1; cycle();
    end
    settle();
    chk("R3 drained", int'(rx_level), 0);
    chk("R11 sticky", int'(rx_overrun), 1);
    rxp(8'h55); rxp(8'h66);
    cfg(8'h03);
    chk("R4 rx flush", int'(rx_level), 0);
    chk("R11 cleared by flush", int'(rx_overrun), 0);

    // R4 byte-mode flush ignored, zero bit no effect
    cfg(8'h00);
    rxp(8'h77); settle();
    cfg(8'h02);
    chk("R4 byte mode flush ignored", int'(rx_level), 1);
    chk("R4 data kept", int'(rx_rdata), 8'h77);
    cfg(8'h00);
    chk("R4 zero bit", int'(rx_level), 1);

    // R5 R6 transmit flush and mode switch
    cfg(8'h01);
    txp(8'h31); txp(8'h32); txp(8'h33);
    rxp(8'h41); rxp(8'h42);
    cfg(8'h01);
    chk("R5 zero bit tx", int'(tx_level), 3);
    chk("R3 tx oldest", int'(tx_rdata), 8'h31);
    cfg(8'h05);
    chk("R5 tx flushed", int'(tx_level), 0);
    chk("R5 rx untouched", int'(rx_level), 2);
    txp(8'h34);
    cfg(8'h00);
    chk("R6 rx emptied", int'(rx_level), 0);
    chk("R6 tx kept", int'(tx_level), 1);
    cfg(8'h04);
    chk("R5 byte mode tx flush ignored", int'(tx_level), 1);
    chk("R2 byte tx full", int'(tx_level), 1);

    // R12 flush and push in the same cycle
    cfg(8'h01);
    rxp(8'h01); rxp(8'h02); rxp(8'h03);
    cfg_we = 1'b1; cfg_wdata = 8'h03; rx_push = 1'b1; rx_wdata = 8'h99;
    settle();
    chk("R12 rx flush beats push", int'(rx_level), 0);
    txp(8'h01); txp(8'h02);
    cfg_we = 1'b1; cfg_wdata = 8'h05; tx_push = 1'b1; tx_wdata = 8'h98;
    settle();
    chk("R12 tx flush beats push", int'(tx_level), 0);

    // R13 empty pop and simultaneous push/pop
    rx_pop = 1'b1; settle();
    chk("R13 empty pop", int'(rx_level), 0);
    rxp(8'hC1); rxp(8'hC2);
    rx_pop = 1'b1; rx_push = 1'b1; rx_wdata = 8'hC3; settle();
    chk("R13 push+pop level", int'(rx_level), 2);
    chk("R13 push+pop head", int'(rx_rdata), 8'hC2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule